// File: doc/BRIEF.md
# Block Address Translation Matcher

This block translates a 32-bit effective address through two small banks of block-translation entries: one bank serves instruction fetches and the other serves loads and stores. Each entry is a pair of 32-bit words. The upper word holds the effective block base, a block-length field and two mode-valid bits. The lower word holds the real block base and a two-bit protection code. The entries are scanned in index order, and the lowest-numbered entry that is valid and matches wins. The winning entry gives a page-aligned real address and a read/write/execute permission set.

A lookup is started with a one-cycle strobe. The block registers the translated address, the permission set, a hit or miss flag and any protection fault. A fault comes with a status code, and a data fault also captures the faulting address. The outputs stay unchanged until the next strobe. The entries are loaded through a plain word write port. There is no read-back path.

Top module: `bat_matcher`

## Requirements
- R1: `lk_type_i` selects the bank. Code 2 (fetch) searches the instruction bank. Code 0 (read) and code 1 (write) search the data bank. An entry in the other bank never produces a hit.
- R2: Upper-word bit 1 enables an entry in supervisor mode (`user_i`=0). Upper-word bit 0 enables it in user mode (`user_i`=1). An entry whose bit for the current mode is clear never hits.
- R3: The compare mask is 0xFFFE0000 AND NOT((upper AND 0x00001FFC) << 15). An entry hits when the mask is nonzero and (EA AND mask) equals (upper AND 0xFFFE0000).
- R4: On a hit, `raddr_o` = ((lower AND mask) OR (EA AND NOT mask)) with bits 11:0 cleared.
- R5: The protection code is lower-word bits 1:0, and `prot_o` is {x,w,r}. Code 0 grants nothing. Any nonzero code grants r and x. Code 2 also grants w.
- R6: When several entries of the searched bank hit, the entry with the lowest index is used.
- R7: A permission shortfall on a hit raises a fault. A fetch sets `ifault_o` with code 0x08000000 and `fault_addr_o`=0. A read sets `dfault_o` with code 0x08000000, and a write sets `dfault_o` with code 0x0A000000. For both data faults `fault_addr_o` = EA.
- R8: A miss sets `miss_o`=1 and `hit_o`=0. It also gives `raddr_o`=0, `prot_o`=0, both fault flags 0 and `fault_code_o`=0.
- R9: All results change only on the clock edge that samples `lk_valid_i`=1. `res_valid_o` is high for exactly the following cycle. Results hold while no strobe arrives.
- R10: After reset every entry is zero, so nothing is valid, and every output is 0.
- R11: A write with `wr_en_i`=1 stores `wr_data_i` into the bank chosen by `wr_bank_i` (1 = instruction), the entry chosen by `wr_idx_i`, and the upper word if `wr_hi_i`=1 or the lower word otherwise. A lookup in the same cycle still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Entry word write strobe |
| wr_bank_i | input | 1 | 1 = instruction bank, 0 = data bank |
| wr_idx_i | input | 2 | Entry index |
| wr_hi_i | input | 1 | 1 = upper word, 0 = lower word |
| wr_data_i | input | 32 | Write data |
| lk_valid_i | input | 1 | Lookup strobe |
| lk_ea_i | input | 32 | Effective address |
| lk_type_i | input | 2 | 0 read, 1 write, 2 fetch |
| user_i | input | 1 | 1 = user mode, 0 = supervisor |
| res_valid_o | output | 1 | Result updated last edge |
| hit_o | output | 1 | Lookup hit |
| miss_o | output | 1 | Lookup missed |
| raddr_o | output | 32 | Page-aligned real address |
| prot_o | output | 3 | Granted {x,w,r} |
| ifault_o | output | 1 | Instruction protection fault |
| dfault_o | output | 1 | Data protection fault |
| fault_code_o | output | 32 | Fault status code |
| fault_addr_o | output | 32 | Faulting data address |

## Verification
The directed patterns cover several separate cases. One address matches two overlapping entries, which shows whether the lowest index wins. The same address is tried as fetch and as data, which shows whether the right bank is used. The same entry is accessed in supervisor and user mode, which tests the two mode-valid bits. Block lengths of 128 KB, 256 KB and 256 MB are checked, including an address just outside a small block, which shows whether the right bits are masked. Protection codes 0, 1 and 2 are combined with read, write and fetch, which separates the status codes and the capture of the faulting address. A random sweep over the programmed regions, with mixed modes and types, is compared against the behavioural model on every clock, and so are the idle cycles that must hold the last result.

// File: rtl/bat_pkg.sv
package bat_pkg;
  localparam int unsigned AW        = 32;
  localparam int unsigned PAGE_BITS = 12;
  localparam logic [AW-1:0] EPI_FIELD = 32'hFFFE_0000;
  localparam logic [AW-1:0] BL_FIELD  = 32'h0000_1FFC;
  localparam int unsigned   BL_SHIFT  = 15;
  localparam int unsigned   SV_BIT    = 1;
  localparam int unsigned   UV_BIT    = 0;
  localparam logic [AW-1:0] PAGE_MASK = ~((AW'(1) << PAGE_BITS) - AW'(1));
  localparam logic [AW-1:0] CODE_PROT = 32'h0800_0000;
  localparam logic [AW-1:0] CODE_STPROT = 32'h0A00_0000;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;
endpackage

// File: rtl/bat_pick.sv
module bat_pick #(
  parameter int unsigned N  = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/bat_bank.sv
module bat_bank
  import bat_pkg::*;
#(
  parameter int unsigned N  = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic          wr_hi_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic [AW-1:0] ea_i,
  input  logic          user_i,
  output logic          hit_o,
  output logic [AW-1:0] raddr_o,
  output logic [1:0]    pp_o
);
  logic [AW-1:0] up_q [N];
  logic [AW-1:0] lo_q [N];
  logic [AW-1:0] ra   [N];
  logic [N-1:0]  hit_vec;
  logic [IW-1:0] sel;

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic          ent_ok;
    logic [AW-1:0] mask;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        up_q[g] <= '0;
        lo_q[g] <= '0;
      end else if (wr_en_i && wr_idx_i == IW'(g)) begin
        if (wr_hi_i) up_q[g] <= wr_data_i;
        else         lo_q[g] <= wr_data_i;
      end
    end

    always_comb begin
      ent_ok     = user_i ? up_q[g][UV_BIT] : up_q[g][SV_BIT];
      mask       = EPI_FIELD & ~((up_q[g] & BL_FIELD) << BL_SHIFT);
      hit_vec[g] = ent_ok && (mask != '0) && ((ea_i & mask) == (up_q[g] & EPI_FIELD));
      ra[g]      = ((lo_q[g] & mask) | (ea_i & ~mask)) & PAGE_MASK;
    end
  end

  bat_pick #(.N(N)) u_pick (
    .req_i (hit_vec),
    .any_o (hit_o),
    .idx_o (sel)
  );

  assign raddr_o = ra[sel];
  assign pp_o    = lo_q[sel][1:0];

  // R6: the selected entry is a hit and no lower entry hits
  always_comb begin
    if (rst_ni && hit_o) begin
      assert_lowest_first_R6: assert (hit_vec[sel] && ((hit_vec & ((N'(1) << sel) - N'(1))) == '0));
    end
  end
endmodule

// File: rtl/bat_perm.sv
module bat_perm
  import bat_pkg::*;
(
  input  logic          hit_i,
  input  logic [1:0]    pp_i,
  input  logic [1:0]    type_i,
  input  logic [AW-1:0] ea_i,
  output perm_t         prot_o,
  output logic          ifault_o,
  output logic          dfault_o,
  output logic [AW-1:0] code_o,
  output logic [AW-1:0] faddr_o
);
  logic need_ok;
  logic fetch;

  always_comb begin
    prot_o.r = hit_i && (pp_i != 2'd0);
    prot_o.x = hit_i && (pp_i != 2'd0);
    prot_o.w = hit_i && (pp_i == 2'd2);
    fetch    = (type_i == ACC_FETCH);
    unique case (type_i)
      ACC_FETCH: need_ok = prot_o.x;
      ACC_WRITE: need_ok = prot_o.w;
      default:   need_ok = prot_o.r;
    endcase
    ifault_o = hit_i && !need_ok && fetch;
    dfault_o = hit_i && !need_ok && !fetch;
    code_o   = '0;
    faddr_o  = '0;
    if (ifault_o) code_o = CODE_PROT;
    if (dfault_o) begin
      code_o  = (type_i == ACC_WRITE) ? CODE_STPROT : CODE_PROT;
      faddr_o = ea_i;
    end
  end
endmodule

// File: rtl/bat_matcher.sv
module bat_matcher
  import bat_pkg::*;
#(
  parameter int unsigned N_ENT = 4,
  localparam int unsigned IW   = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_bank_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic          wr_hi_i,
  input  logic [31:0]   wr_data_i,
  input  logic          lk_valid_i,
  input  logic [31:0]   lk_ea_i,
  input  logic [1:0]    lk_type_i,
  input  logic          user_i,
  output logic          res_valid_o,
  output logic          hit_o,
  output logic          miss_o,
  output logic [31:0]   raddr_o,
  output logic [2:0]    prot_o,
  output logic          ifault_o,
  output logic          dfault_o,
  output logic [31:0]   fault_code_o,
  output logic [31:0]   fault_addr_o
);
  localparam int unsigned NB = 2;  // 0 data, 1 instruction

  logic          b_hit   [NB];
  logic [AW-1:0] b_raddr [NB];
  logic [1:0]    b_pp    [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    bat_bank #(.N(N_ENT)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i && (wr_bank_i == b[0])),
      .wr_idx_i  (wr_idx_i),
      .wr_hi_i   (wr_hi_i),
      .wr_data_i (wr_data_i),
      .ea_i      (lk_ea_i),
      .user_i    (user_i),
      .hit_o     (b_hit[b]),
      .raddr_o   (b_raddr[b]),
      .pp_o      (b_pp[b])
    );
  end

  logic          use_i;
  logic          hit_c;
  logic [AW-1:0] ra_c;
  perm_t         prot_c;
  logic          if_c, df_c;
  logic [AW-1:0] code_c, fa_c;

  assign use_i = (lk_type_i == ACC_FETCH);
  assign hit_c = b_hit[use_i];
  assign ra_c  = hit_c ? b_raddr[use_i] : '0;

  bat_perm u_perm (
    .hit_i    (hit_c),
    .pp_i     (b_pp[use_i]),
    .type_i   (lk_type_i),
    .ea_i     (lk_ea_i),
    .prot_o   (prot_c),
    .ifault_o (if_c),
    .dfault_o (df_c),
    .code_o   (code_c),
    .faddr_o  (fa_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o  <= 1'b0;
      hit_o        <= 1'b0;
      miss_o       <= 1'b0;
      raddr_o      <= '0;
      prot_o       <= '0;
      ifault_o     <= 1'b0;
      dfault_o     <= 1'b0;
      fault_code_o <= '0;
      fault_addr_o <= '0;
    end else begin
      res_valid_o <= lk_valid_i;
      if (lk_valid_i) begin
        hit_o        <= hit_c;
        miss_o       <= !hit_c;
        raddr_o      <= ra_c;
        prot_o       <= prot_c;
        ifault_o     <= if_c;
        dfault_o     <= df_c;
        fault_code_o <= code_c;
        fault_addr_o <= fa_c;
      end
    end
  end

  assert_hit_xor_miss_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (hit_o != miss_o));

  assert_miss_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (raddr_o == '0 && prot_o == '0 && !ifault_o && !dfault_o && fault_code_o == '0));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> ($stable(raddr_o) && $stable(hit_o) && $stable(fault_code_o) && !res_valid_o));

  assert_fetch_fault_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && ifault_o) |-> ($past(lk_type_i) == ACC_FETCH && fault_addr_o == '0));

  assert_data_fault_addr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && dfault_o) |-> (fault_addr_o == $past(lk_ea_i) && $past(lk_type_i) != ACC_FETCH));

  assert_one_fault_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ifault_o, dfault_o}));

  assert_write_has_rx_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_o[1] |-> (prot_o[0] && prot_o[2]));
endmodule

// File: tb/sim_bat_matcher.sv
module sim_bat_matcher;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_bank = 1'b0, wr_hi = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        lk_valid = 1'b0, user = 1'b0;
  logic [31:0] lk_ea = '0;
  logic [1:0]  lk_type = '0;

  logic        res_valid, hit, miss, ifault, dfault;
  logic [31:0] raddr, fcode, faddr;
  logic [2:0]  prot;

  int n_vec = 0, n_bad = 0;
  string cur_req = "R10";

  always #10 clk = ~clk;  // 50 MHz

  bat_matcher u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_bank_i(wr_bank), .wr_idx_i(wr_idx), .wr_hi_i(wr_hi), .wr_data_i(wr_data),
    .lk_valid_i(lk_valid), .lk_ea_i(lk_ea), .lk_type_i(lk_type), .user_i(user),
    .res_valid_o(res_valid), .hit_o(hit), .miss_o(miss), .raddr_o(raddr), .prot_o(prot),
    .ifault_o(ifault), .dfault_o(dfault), .fault_code_o(fcode), .fault_addr_o(faddr)
  );

  // behavioural reference model
  logic [31:0] m_up [0:1][0:3];
  logic [31:0] m_lo [0:1][0:3];
  logic        e_val, e_hit, e_miss, e_if, e_df;
  logic [31:0] e_ra, e_code, e_fa;
  logic [2:0]  e_prot;

  task automatic model_eval(input logic [31:0] ea, input logic [1:0] ty, input logic usr,
                            output logic h, output logic [31:0] ra, output logic [2:0] pr,
                            output logic fi, output logic fd, output logic [31:0] cd,
                            output logic [31:0] fa);
    int bk;
    int pp;
    bit ok;
    bk = (ty == 2) ? 1 : 0;
    h = 0; ra = 0; pr = 0; fi = 0; fd = 0; cd = 0; fa = 0; pp = 0;
    for (int i = 0; i < 4; i++) begin
      longint blk;
      logic [31:0] m, u, l;
      u = m_up[bk][i];
      l = m_lo[bk][i];
      blk = longint'(u & 32'h1FFC) * 32768;
      m = 32'hFFFE_0000 & ~32'(blk);
      if (!h && (usr ? u[0] : u[1]) && m != 0 && (ea & m) == (u & 32'hFFFE_0000)) begin
        h  = 1;
        ra = ((l & m) | (ea & ~m)) & 32'hFFFF_F000;
        pp = int'(l[1:0]);
      end
    end
    if (h) begin
      pr = (pp == 0) ? 3'b000 : (pp == 2) ? 3'b111 : 3'b101;
      ok = (ty == 2) ? pr[2] : (ty == 1) ? pr[1] : pr[0];
      if (!ok) begin
        if (ty == 2) begin fi = 1; cd = 32'h0800_0000; end
        else begin fd = 1; fa = ea; cd = (ty == 1) ? 32'h0A00_0000 : 32'h0800_0000; end
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) for (int i = 0; i < 4; i++) begin
        m_up[b][i] <= '0; m_lo[b][i] <= '0;
      end
      e_val <= 0; e_hit <= 0; e_miss <= 0; e_ra <= 0; e_prot <= 0;
      e_if <= 0; e_df <= 0; e_code <= 0; e_fa <= 0;
    end else begin
      logic h, fi, fd; logic [31:0] ra, cd, fa; logic [2:0] pr;
      e_val <= lk_valid;
      if (lk_valid) begin
        model_eval(lk_ea, lk_type, user, h, ra, pr, fi, fd, cd, fa);
        e_hit <= h; e_miss <= !h; e_ra <= ra; e_prot <= pr;
        e_if <= fi; e_df <= fd; e_code <= cd; e_fa <= fa;
      end
      if (wr_en) begin
        if (wr_hi) m_up[wr_bank][wr_idx] <= wr_data;
        else       m_lo[wr_bank][wr_idx] <= wr_data;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_vec++;
      if ({res_valid, hit, miss, raddr, prot, ifault, dfault, fcode, faddr} !==
          {e_val, e_hit, e_miss, e_ra, e_prot, e_if, e_df, e_code, e_fa}) begin
        n_bad++;
        $display("FAIL %s model: v%b h%b m%b ra=%h p=%b if%b df%b c=%h fa=%h exp v%b h%b m%b ra=%h p=%b if%b df%b c=%h fa=%h",
                 cur_req, res_valid, hit, miss, raddr, prot, ifault, dfault, fcode, faddr,
                 e_val, e_hit, e_miss, e_ra, e_prot, e_if, e_df, e_code, e_fa);
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic bk, input int idx, input logic hi, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1; wr_bank = bk; wr_idx = 2'(idx); wr_hi = hi; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  // strobe one lookup, then check at the next negedge
  task automatic look(input string req, input logic [31:0] ea, input logic [1:0] ty, input logic usr,
                      input logic exp_hit, input logic [31:0] exp_ra, input logic [31:0] exp_code);
    cur_req = req;
    @(posedge clk); #1;
    lk_valid = 1; lk_ea = ea; lk_type = ty; user = usr;
    @(posedge clk); #1;
    lk_valid = 0;
    @(negedge clk);
    chk(req, {31'd0, hit, raddr}, {31'd0, exp_hit, exp_ra});
    chk(req, {32'd0, fcode}, {32'd0, exp_code});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", {res_valid, hit, miss, ifault, dfault, prot, raddr, fcode[23:0]}, 64'd0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk("R10", {31'd0, hit, raddr}, 64'd0);

    cur_req = "R11";
    wr(0, 0, 1, 32'h1000_0003); wr(0, 0, 0, 32'h8000_0002);
    wr(0, 1, 1, 32'h1000_1FFF); wr(0, 1, 0, 32'h9000_0001);
    wr(0, 2, 1, 32'h2000_0003); wr(0, 2, 0, 32'h4000_0000);
    wr(0, 3, 1, 32'h4000_0006); wr(0, 3, 0, 32'h7000_0002);
    wr(1, 0, 1, 32'h6000_0003); wr(1, 0, 0, 32'h5000_0000);
    wr(1, 1, 1, 32'h3000_0003); wr(1, 1, 0, 32'h5000_0001);

    look("R4", 32'h1001_2345, 0, 0, 1, 32'h8001_2000, 0);
    chk("R5", {61'd0, prot}, 64'd7);
    @(negedge clk);
    chk("R9", {31'd0, res_valid, raddr}, {32'd0, 32'h8001_2000});
    look("R6", 32'h1001_2345, 0, 1, 1, 32'h8001_2000, 0);
    look("R3", 32'h1234_5678, 0, 1, 1, 32'h9234_5000, 0);
    chk("R5", {61'd0, prot}, 64'd5);
    look("R7", 32'h1234_5678, 1, 1, 1, 32'h9234_5000, 32'h0A00_0000);
    chk("R7", {31'd0, dfault, faddr}, {32'd1, 32'h1234_5678});
    look("R5", 32'h2000_0010, 0, 0, 1, 32'h4000_0000, 32'h0800_0000);
    chk("R7", {31'd0, dfault, faddr}, {32'd1, 32'h2000_0010});
    look("R3", 32'h4002_3456, 0, 0, 1, 32'h7002_3000, 0);
    look("R2", 32'h4002_3456, 0, 1, 0, 32'h0, 0);
    look("R3", 32'h4004_0000, 0, 0, 0, 32'h0, 0);
    chk("R8", {61'd0, miss, ifault, dfault}, 64'h4);
    look("R1", 32'h3000_1ABC, 2, 1, 1, 32'h5000_1000, 0);
    look("R1", 32'h3000_1ABC, 0, 1, 0, 32'h0, 0);
    look("R7", 32'h6000_0000, 2, 0, 1, 32'h5000_0000, 32'h0800_0000);
    chk("R7", {31'd0, ifault, faddr}, {32'd1, 32'd0});
    look("R1", 32'h1001_2345, 2, 0, 0, 32'h0, 0);
    look("R5", 32'h1001_2345, 1, 0, 1, 32'h8001_2000, 0);
    wr(0, 0, 0, 32'h8800_0002);
    wr(1, 0, 1, 32'h1000_0003);
    look("R11", 32'h1001_2345, 0, 0, 1, 32'h8801_2000, 0);

    cur_req = "R6";
    for (int k = 0; k < 300; k++) begin
      logic [31:0] ea;
      int sel;
      sel = int'($urandom_range(0, 5));
      ea = $urandom;
      ea[31:28] = (sel == 0) ? 4'h1 : (sel == 1) ? 4'h2 : (sel == 2) ? 4'h3 :
                  (sel == 3) ? 4'h4 : (sel == 4) ? 4'h6 : 4'h7;
      if (ea[0]) ea[27:18] = '0;
      @(posedge clk); #1;
      lk_valid = $urandom_range(0, 3) != 0;
      lk_ea = ea; lk_type = 2'($urandom_range(0, 2)); user = 1'($urandom_range(0, 1));
    end
    @(posedge clk); #1 lk_valid = 0;
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule